// File: doc/BRIEF.md
# Receive Pulse Conditioner

This block sits at the front of a pulse-capture receive channel. It brings a raw, asynchronous input pin into the clock domain and removes pulses too narrow to be real. It then measures, in units of a divided tick, how long each filtered level lasts. Every time the filtered line changes level during a capture, the block emits one record. A record holds the measured tick count and the level that held for that time. When the line stays at one level for longer than a programmable idle threshold, the block closes the capture. It emits the final record together with a one-cycle done pulse and then waits for the next filtered edge.

Records leave on a valid/ready stream. A record stays on the outputs unchanged until the consumer accepts it. The output register holds exactly one record. If a new record is produced while the held one is still unaccepted, the new record is discarded, because a live line cannot be stalled. The consumer therefore has to accept each record before the next level change arrives. The receive enable is a requested value that only takes effect on a configuration-update strobe. A pointer-reset input restarts the record position count that is reported with each record.

Top module: `rx_pulse_conditioner`

## Requirements
- R1: With the filter enabled and threshold N, a pin pulse lasting N clock cycles or fewer is removed entirely. A pulse lasting more than N cycles passes with its width unchanged.
- R2: With the filter disabled, every level change on the pin passes, including single-cycle pulses, and the configured threshold has no effect.
- R3: During a capture, each filtered level change emits a record with the tick count of the level that just ended and that level. A tick that arrives in the cycle of the change counts toward the new level.
- R4: When a level has already counted the maximum tick count (2^DUR_W-1) and one more tick arrives without an edge and without the line going idle, the block emits a record with the maximum count. Counting for the same level then continues from 1.
- R5: Once the ticks since the last level change exceed the idle threshold, the block emits the remaining count as a final record. Together with R4 this makes the durations of one level sum to the threshold. The done output is high for exactly one cycle, in the cycle in which that final record first appears as valid.
- R6: After a capture has ended, no record is produced until the next filtered edge. That edge starts a new capture without emitting a record.
- R7: The receive enable changes only in a cycle with the configuration-update strobe. While receive is off, no record and no done is produced. Switching receive off mid-capture abandons the capture without a record.
- R8: While a record is valid and not ready, its duration, level and index stay stable. A record produced while the output is still held is dropped, and the held record is kept.
- R9: The record index starts at 0 and advances by one, modulo 2^IDX_W, on each accepted record. A pointer reset returns it to 0 in the next cycle and takes priority over advancing.
- R10: After reset, valid and done are low, the index is 0 and receive is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw receive pin, asynchronous |
| tick_en | input | 1 | Divided tick, one-cycle enable |
| filt_en | input | 1 | Glitch filter enable |
| filt_thr | input | FILT_W | Widest pulse, in clock cycles, treated as noise |
| idle_thr | input | IDLE_W | Ticks without a level change that end a capture |
| rx_en_req | input | 1 | Requested receive enable |
| cfg_upd | input | 1 | Strobe that applies rx_en_req |
| ptr_rst | input | 1 | Restart the record index |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_dur | output | DUR_W | Tick count of the recorded level |
| rec_level | output | 1 | Level that lasted rec_dur ticks |
| rec_idx | output | IDX_W | Position of the held record |
| rx_done | output | 1 | One-cycle pulse when a capture ends |

## Verification
The bench builds the block with DUR_W=4, IDLE_W=6, FILT_W=3 and IDX_W=3. With these values the tick counter saturates after 15 ticks, so levels longer than 15 ticks split into several records within a few dozen cycles. Idle thresholds of 20 and 50 are small enough that every capture closes quickly. Two of them are above the saturation point, so the final record of a capture follows one or more records at maximum count. The record index wraps after eight accepted records, and the filter thresholds allow pulses exactly at, and one cycle above, the noise width. Expected durations come from the driven pin lengths and the tick pattern, split into chunks of at most 15 ticks.

// File: rtl/rxpc_pkg.sv
package rxpc_pkg;

  typedef enum logic {
    CAP_WAIT = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;

endpackage

// File: rtl/rxpc_glitch_filter.sv
module rxpc_glitch_filter #(
  parameter int   FILT_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              filt_en,
  input  logic [FILT_W-1:0] filt_thr,
  output logic              lvl_o
);

  localparam logic [FILT_W-1:0] CNT_ONE = FILT_W'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_lvl;
  logic [FILT_W-1:0]      run_q;
  logic [FILT_W-1:0]      thr_eff;
  logic                   lvl_q;

  // synchroniser chain, first stage takes the pin
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= IDLE_LEVEL;
          else        sync_q[gi] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= IDLE_LEVEL;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  // a disabled filter behaves as a zero-width noise threshold
  assign thr_eff = filt_en ? filt_thr : '0;

  // a new level is accepted once it has differed for thr_eff+1 cycles in a row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= IDLE_LEVEL;
      run_q <= '0;
    end else if (sync_lvl == lvl_q) begin
      run_q <= '0;
    end else if (run_q >= thr_eff) begin
      lvl_q <= sync_lvl;
      run_q <= '0;
    end else begin
      run_q <= run_q + CNT_ONE;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/rxpc_edge_timer.sv
module rxpc_edge_timer
  import rxpc_pkg::*;
#(
  parameter int DUR_W  = 15,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic              tick_i,
  input  logic              rx_on_i,
  input  logic [IDLE_W-1:0] idle_thr_i,
  output logic              ev_valid_o,
  output logic [DUR_W-1:0]  ev_dur_o,
  output logic              ev_lvl_o,
  output logic              ev_last_o
);

  localparam logic [DUR_W-1:0]  DUR_MAX = '1;
  localparam logic [DUR_W-1:0]  DUR_ONE = DUR_W'(1);
  localparam logic [IDLE_W:0]   IDL_ONE = (IDLE_W+1)'(1);

  cap_state_e        state_q;
  logic              cur_q;
  logic [DUR_W-1:0]  dur_q;
  logic [IDLE_W-1:0] idl_q;
  logic              edge_seen;
  logic [IDLE_W:0]   idl_inc;
  logic              goes_idle;
  logic [DUR_W-1:0]  dur_start;
  logic [IDLE_W-1:0] idl_start;

  assign edge_seen = (lvl_i != cur_q);
  assign idl_inc   = {1'b0, idl_q} + IDL_ONE;
  assign goes_idle = idl_inc > {1'b0, idle_thr_i};
  assign dur_start = {{(DUR_W-1){1'b0}}, tick_i};
  assign idl_start = {{(IDLE_W-1){1'b0}}, tick_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CAP_WAIT;
      cur_q      <= 1'b0;
      dur_q      <= '0;
      idl_q      <= '0;
      ev_valid_o <= 1'b0;
      ev_dur_o   <= '0;
      ev_lvl_o   <= 1'b0;
      ev_last_o  <= 1'b0;
    end else begin
      ev_valid_o <= 1'b0;
      ev_last_o  <= 1'b0;
      if (!rx_on_i) begin
        // receive off: follow the line so the first edge after enable is real
        state_q <= CAP_WAIT;
        cur_q   <= lvl_i;
      end else begin
        unique case (state_q)
          CAP_WAIT: begin
            if (edge_seen) begin
              state_q <= CAP_RUN;
              cur_q   <= lvl_i;
              dur_q   <= dur_start;
              idl_q   <= idl_start;
            end
          end
          CAP_RUN: begin
            if (edge_seen) begin
              ev_valid_o <= 1'b1;
              ev_dur_o   <= dur_q;
              ev_lvl_o   <= cur_q;
              cur_q      <= lvl_i;
              dur_q      <= dur_start;
              idl_q      <= idl_start;
            end else if (tick_i) begin
              if (goes_idle) begin
                ev_valid_o <= 1'b1;
                ev_last_o  <= 1'b1;
                ev_dur_o   <= dur_q;
                ev_lvl_o   <= cur_q;
                state_q    <= CAP_WAIT;
              end else begin
                idl_q <= idl_inc[IDLE_W-1:0];
                if (dur_q == DUR_MAX) begin
                  ev_valid_o <= 1'b1;
                  ev_dur_o   <= DUR_MAX;
                  ev_lvl_o   <= cur_q;
                  dur_q      <= DUR_ONE;
                end else begin
                  dur_q <= dur_q + DUR_ONE;
                end
              end
            end
          end
          default: state_q <= CAP_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxpc_out_stage.sv
module rxpc_out_stage #(
  parameter int DUR_W = 15,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid_i,
  input  logic [DUR_W-1:0] ev_dur_i,
  input  logic             ev_lvl_i,
  input  logic             ev_last_i,
  input  logic             ptr_rst_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [DUR_W-1:0] dur_o,
  output logic             lvl_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic valid_q;
  logic fire;
  logic can_load;

  assign fire     = valid_q & ready_i;
  assign can_load = ~valid_q | ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dur_o   <= '0;
      lvl_o   <= 1'b0;
    end else if (ev_valid_i && can_load) begin
      valid_q <= 1'b1;
      dur_o   <= ev_dur_i;
      lvl_o   <= ev_lvl_i;
    end else if (fire) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_o <= '0;
    else if (ptr_rst_i) idx_o <= '0;
    else if (fire)      idx_o <= idx_o + IDX_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= ev_valid_i & ev_last_i;
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/rx_pulse_conditioner.sv
module rx_pulse_conditioner #(
  parameter int   DUR_W       = 15,
  parameter int   IDLE_W      = 16,
  parameter int   FILT_W      = 8,
  parameter int   IDX_W       = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              tick_en,
  input  logic              filt_en,
  input  logic [FILT_W-1:0] filt_thr,
  input  logic [IDLE_W-1:0] idle_thr,
  input  logic              rx_en_req,
  input  logic              cfg_upd,
  input  logic              ptr_rst,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [DUR_W-1:0]  rec_dur,
  output logic              rec_level,
  output logic [IDX_W-1:0]  rec_idx,
  output logic              rx_done
);

  logic             filt_lvl;
  logic             rx_on_q;
  logic             ev_valid;
  logic [DUR_W-1:0] ev_dur;
  logic             ev_lvl;
  logic             ev_last;

  // receive enable is latched only on the update strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_on_q <= 1'b0;
    else if (cfg_upd) rx_on_q <= rx_en_req;
  end

  rxpc_glitch_filter #(
    .FILT_W      (FILT_W),
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_LEVEL  (IDLE_LEVEL)
  ) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .filt_en  (filt_en),
    .filt_thr (filt_thr),
    .lvl_o    (filt_lvl)
  );

  rxpc_edge_timer #(
    .DUR_W  (DUR_W),
    .IDLE_W (IDLE_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (filt_lvl),
    .tick_i     (tick_en),
    .rx_on_i    (rx_on_q),
    .idle_thr_i (idle_thr),
    .ev_valid_o (ev_valid),
    .ev_dur_o   (ev_dur),
    .ev_lvl_o   (ev_lvl),
    .ev_last_o  (ev_last)
  );

  rxpc_out_stage #(
    .DUR_W (DUR_W),
    .IDX_W (IDX_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid_i (ev_valid),
    .ev_dur_i   (ev_dur),
    .ev_lvl_i   (ev_lvl),
    .ev_last_i  (ev_last),
    .ptr_rst_i  (ptr_rst),
    .ready_i    (rec_ready),
    .valid_o    (rec_valid),
    .dur_o      (rec_dur),
    .lvl_o      (rec_level),
    .idx_o      (rec_idx),
    .done_o     (rx_done)
  );

endmodule

// File: rtl/rx_pulse_conditioner_chk.sv
module rx_pulse_conditioner_chk #(
  parameter int DUR_W = 15,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [DUR_W-1:0] rec_dur,
  input logic             rec_level,
  input logic [IDX_W-1:0] rec_idx,
  input logic             rx_done,
  input logic             ptr_rst,
  input logic             cfg_upd,
  input logic             rx_on
);

  // R8: a held record does not move while the consumer stalls
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready && !ptr_rst) |=>
      (rec_valid && $stable(rec_dur) && $stable(rec_level) && $stable(rec_idx)));

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R5: done always comes with a record on the outputs
  a_r5_done_with_rec: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rec_valid);

  // R9: pointer reset clears the index in the next cycle
  a_r9_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> (rec_idx == '0));

  // R9: each accepted record advances the index by one
  a_r9_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && !ptr_rst) |=> (rec_idx == IDX_W'($past(rec_idx) + 1'b1)));

  // R7: receive enable only moves on the update strobe
  a_r7_enable_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_upd |=> $stable(rx_on));

endmodule

bind rx_pulse_conditioner rx_pulse_conditioner_chk #(
  .DUR_W (DUR_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_dur   (rec_dur),
  .rec_level (rec_level),
  .rec_idx   (rec_idx),
  .rx_done   (rx_done),
  .ptr_rst   (ptr_rst),
  .cfg_upd   (cfg_upd),
  .rx_on     (rx_on_q)
);

// File: tb/rx_pulse_conditioner_tb_top.sv
`timescale 1ns/1ps
module rx_pulse_conditioner_tb_top;

  localparam int DUR_W  = 4;
  localparam int IDLE_W = 6;
  localparam int FILT_W = 3;
  localparam int IDX_W  = 3;
  localparam int DMAX   = (1 << DUR_W) - 1;
  localparam int IDXN   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pin_i = 1'b0;
  logic              tick_en = 1'b1;
  logic              tick_alt = 1'b0;
  logic              filt_en = 1'b0;
  logic [FILT_W-1:0] filt_thr = '0;
  logic [IDLE_W-1:0] idle_thr = '0;
  logic              rx_en_req = 1'b0;
  logic              cfg_upd = 1'b0;
  logic              ptr_rst = 1'b0;
  logic              rec_ready = 1'b1;
  logic              rec_valid;
  logic [DUR_W-1:0]  rec_dur;
  logic              rec_level;
  logic [IDX_W-1:0]  rec_idx;
  logic              rx_done;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int idx_model = 0;
  bit finished = 0;
  int exp_dur[$], exp_lvl[$], exp_last[$];
  int got_dur[$], got_lvl[$], got_last[$];

  always #4 clk = ~clk;

  rx_pulse_conditioner #(
    .DUR_W(DUR_W), .IDLE_W(IDLE_W), .FILT_W(FILT_W), .IDX_W(IDX_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tick_en(tick_en),
    .filt_en(filt_en), .filt_thr(filt_thr), .idle_thr(idle_thr),
    .rx_en_req(rx_en_req), .cfg_upd(cfg_upd), .ptr_rst(ptr_rst),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_dur(rec_dur),
    .rec_level(rec_level), .rec_idx(rec_idx), .rx_done(rx_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // tick every cycle, or every other cycle when tick_alt is set
  always @(negedge clk) tick_en <= tick_alt ? ~tick_en : 1'b1;

  // monitor samples mid low phase, away from both edges
  always begin
    @(negedge clk);
    #2;
    if (rst_n && rec_valid && rec_ready) begin
      got_dur.push_back(int'(rec_dur));
      got_lvl.push_back(int'(rec_level));
      got_last.push_back(int'(rx_done));
      check(int'(rec_idx) == idx_model % IDXN, "R9", int'(rec_idx), idx_model % IDXN, "record index");
      idx_model++;
    end
    if (rst_n && rx_done) done_cnt++;
  end

  // expected split of one level: chunks of DMAX, then the remainder
  task automatic expect_level(input int total, input int lvl, input bit last);
    int left = total;
    while (left > DMAX) begin
      exp_dur.push_back(DMAX); exp_lvl.push_back(lvl); exp_last.push_back(0);
      left -= DMAX;
    end
    exp_dur.push_back(left); exp_lvl.push_back(lvl); exp_last.push_back(int'(last));
  endtask

  task automatic hold(input logic lvl, input int n);
    pin_i = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_enable(input logic v);
    rx_en_req = v;
    cfg_upd = 1'b1;
    @(negedge clk);
    cfg_upd = 1'b0;
  endtask

  task automatic compare(input string req);
    check(got_dur.size() == exp_dur.size(), req, got_dur.size(), exp_dur.size(), "record count");
    for (int i = 0; i < exp_dur.size() && i < got_dur.size(); i++) begin
      check(got_dur[i] == exp_dur[i], req, got_dur[i], exp_dur[i], $sformatf("duration #%0d", i));
      check(got_lvl[i] == exp_lvl[i], req, got_lvl[i], exp_lvl[i], $sformatf("level #%0d", i));
      check(got_last[i] == exp_last[i], req, got_last[i], exp_last[i], $sformatf("done flag #%0d", i));
    end
    exp_dur.delete(); exp_lvl.delete(); exp_last.delete();
    got_dur.delete(); got_lvl.delete(); got_last.delete();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int dsnap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R10 reset state
    check(rec_valid == 1'b0, "R10", int'(rec_valid), 0, "valid after reset");
    check(rx_done == 1'b0, "R10", int'(rx_done), 0, "done after reset");
    check(rec_idx == '0, "R10", int'(rec_idx), 0, "index after reset");
    @(negedge clk);

    // R7 / R10: receive is off after reset, and a request without strobe does nothing
    idle_thr = 6'd20;
    hold(1'b1, 5); hold(1'b0, 60);
    rx_en_req = 1'b1;
    hold(1'b1, 5); hold(1'b0, 60);
    check(got_dur.size() == 0, "R7", got_dur.size(), 0, "records while off");
    check(done_cnt == 0, "R7", done_cnt, 0, "done while off");
    apply_enable(1'b1);

    // R3 R4 R5 R6: unfiltered pattern, idle 20 splits into 15+5
    hold(1'b1, 5); hold(1'b0, 3); hold(1'b1, 7); hold(1'b0, 100);
    expect_level(5, 1, 0); expect_level(3, 0, 0); expect_level(7, 1, 0);
    expect_level(20, 0, 1);
    compare("R3_R5");
    check(done_cnt == 1, "R5", done_cnt, 1, "done pulses");

    // R6: nothing while idle at the same level
    hold(1'b0, 40);
    check(got_dur.size() == 0, "R6", got_dur.size(), 0, "records while idle");

    // R1: threshold 3, pulses of 3 dropped, 4 passes
    filt_en = 1'b1; filt_thr = 3'd3;
    hold(1'b1, 6); hold(1'b0, 3); hold(1'b1, 5); hold(1'b0, 4); hold(1'b1, 3); hold(1'b0, 100);
    expect_level(14, 1, 0); expect_level(20, 0, 1);
    compare("R1");

    // R2: filter off, single-cycle pulses pass despite threshold
    filt_en = 1'b0;
    hold(1'b1, 1); hold(1'b0, 1); hold(1'b1, 2); hold(1'b0, 100);
    expect_level(1, 1, 0); expect_level(1, 0, 0); expect_level(2, 1, 0);
    expect_level(20, 0, 1);
    compare("R2");

    // R4: saturation before an edge and before idle, idle 50
    idle_thr = 6'd50;
    hold(1'b1, 33); hold(1'b0, 15); hold(1'b1, 120);
    expect_level(33, 1, 0); expect_level(15, 0, 0); expect_level(50, 1, 1);
    compare("R4");

    // R3: tick every other cycle halves even level lengths
    idle_thr = 6'd20;
    tick_alt = 1'b1;
    hold(1'b0, 10); hold(1'b1, 6); hold(1'b0, 120);
    expect_level(5, 0, 0); expect_level(3, 1, 0); expect_level(20, 0, 1);
    compare("R3_tick");
    tick_alt = 1'b0;
    hold(1'b0, 4);

    // R8: stalled consumer, second record dropped, held one stable
    idle_thr = 6'd10;
    rec_ready = 1'b0;
    dsnap = done_cnt;
    hold(1'b1, 4); hold(1'b0, 60);
    #2;
    check(rec_valid == 1'b1, "R8", int'(rec_valid), 1, "held valid");
    check(int'(rec_dur) == 4, "R8", int'(rec_dur), 4, "held duration");
    check(rec_level == 1'b1, "R8", int'(rec_level), 1, "held level");
    check(done_cnt == dsnap + 1, "R8", done_cnt, dsnap + 1, "done while stalled");
    @(negedge clk);
    rec_ready = 1'b1;
    repeat (3) @(negedge clk);
    expect_level(4, 1, 0);
    compare("R8");
    #2;
    check(rec_valid == 1'b0, "R8", int'(rec_valid), 0, "valid after accept");

    // R9: pointer reset returns index to zero
    @(negedge clk);
    ptr_rst = 1'b1;
    @(negedge clk);
    ptr_rst = 1'b0;
    idx_model = 0;
    #2;
    check(rec_idx == '0, "R9", int'(rec_idx), 0, "index after pointer reset");
    @(negedge clk);
    hold(1'b1, 3); hold(1'b0, 60);
    expect_level(3, 1, 0); expect_level(10, 0, 1);
    compare("R9");

    // R7: disable mid-capture abandons it
    dsnap = done_cnt;
    hold(1'b1, 5);
    apply_enable(1'b0);
    hold(1'b1, 3); hold(1'b0, 60);
    check(got_dur.size() == 0, "R7", got_dur.size(), 0, "records after abort");
    check(done_cnt == dsnap, "R7", done_cnt, dsnap, "done after abort");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule